// File: doc/BRIEF.md
# Serial Pointwise Convolution Engine

This block computes a 1x1 convolution across channels for one pixel at a time. The samples of one pixel arrive one per handshake on a single 8-bit bus, in input-channel order. The block latches each sample and keeps it for COUT clock cycles. In each of those cycles it reads one signed weight from a fixed internal table and multiplies it by the latched sample on the block's only multiplier. It then adds the product into the accumulator of the output channel that the cycle stands for.

When the last input channel of a pixel has been folded in, the block sends the COUT sums out on one result bus, one channel per cycle. A flag marks the first channel of each pixel. Because each sample is held for COUT cycles, one instance can serve only as many output channels as there are hold cycles. A wider layer uses several instances side by side.

A parameter selects one of two options. With a second register bank, the sums are copied out and the next pixel accumulates while the previous one is sent. With a single bank, the input is stalled until serialization ends.

Top module: `pw_conv_serial`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: A sample moves on a cycle where in_valid and in_ready are both 1. The first sample after reset, and the first after a pixel's last channel, is input channel 0. Later samples take channels 1 to CIN-1 in order.
- R3: The weight for input channel i and output channel o is the table entry at address {i, o}. The address is i*2^OCW + o, which is i*4 + o at the defaults. The entry holds the low 8 bits of (29*address + 3), read as a two's-complement number.
- R4: Output channel o carries the sum over i of sample(i) * weight(i, o). This is an exact signed value in the 20-bit result.
- R5: After a sample for any channel other than the last is accepted, in_ready stays 0 for exactly COUT cycles.
- R6: The accumulators restart at the channel-0 sample of each pixel, so a pixel's results do not depend on earlier pixels.
- R7: For each pixel, out_valid is 1 for exactly COUT consecutive cycles, and out_ch counts 0 to COUT-1 over those cycles.
- R8: out_first is 1 only on the cycle that carries output channel 0.
- R9: With DBUF=1, the channel-0 sample of the next pixel can be accepted while the previous pixel is still being sent.
- R10: With DBUF=0, in_ready is 0 on every cycle where out_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample on in_data is offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | 8 | Signed input sample |
| out_valid | output | 1 | out_data holds a result |
| out_first | output | 1 | Result is output channel 0 |
| out_ch | output | 2 | Output channel index of out_data |
| out_data | output | 20 | Signed accumulated result |

## Verification
The checker watches the port protocol on every cycle:
- in_ready drops after each accepted sample.
- out_ch steps by one through each output burst, and the burst opens with out_first.
- With a single bank, in_ready stays low while results go out.

Only the bench scenarios can show the following:
- the arithmetic sums against the weight formula, including the most negative inputs;
- the exact length of the multiply hold;
- clearing of the accumulators between pixels;
- that a second bank really overlaps the next pixel with serialization.

// File: rtl/pw_conv_serial.sv
module pw_conv_serial #(
  parameter int CIN  = 4,
  parameter int COUT = 4,
  parameter int DW   = 8,
  parameter int WW   = 8,
  parameter int AW   = 20,
  parameter int DBUF = 1,
  localparam int ICW = (CIN  > 1) ? $clog2(CIN)  : 1,
  localparam int OCW = (COUT > 1) ? $clog2(COUT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic                 out_first,
  output logic [OCW-1:0]       out_ch,
  output logic signed [AW-1:0] out_data
);
  localparam int ROM_N = 1 << (ICW + OCW);

  logic signed [WW-1:0]    rom [ROM_N];
  logic signed [DW-1:0]    x_q;
  logic [ICW-1:0]          ic_q;
  logic [OCW-1:0]          oc_q, sc_q;
  logic                    busy, done_pend, ser_on, start;
  logic signed [WW-1:0]    w;
  logic signed [DW+WW-1:0] prod;
  logic signed [AW-1:0]    prod_x;
  logic signed [AW-1:0]    acc [COUT];

  for (genvar g = 0; g < ROM_N; g++) begin : g_rom
    assign rom[g] = WW'((g * 29 + 3) % (1 << WW));
  end

  assign w      = rom[{ic_q, oc_q}];
  assign prod   = x_q * w;
  assign prod_x = AW'(prod);

  wire last_oc = (oc_q == OCW'(COUT - 1));
  wire last_ic = (ic_q == ICW'(CIN - 1));
  wire last_sc = (sc_q == OCW'(COUT - 1));

  assign start = done_pend && !ser_on;

  if (DBUF != 0) begin : g_dbuf
    logic signed [AW-1:0] shad [COUT];
    always_ff @(posedge clk)
      if (start)
        for (int i = 0; i < COUT; i++) shad[i] <= acc[i];
    assign out_data = shad[sc_q];
    assign in_ready = !busy && !done_pend;
  end else begin : g_sbuf
    assign out_data = acc[sc_q];
    assign in_ready = !busy && !done_pend && !ser_on;
  end

  always_ff @(posedge clk)
    if (busy)
      acc[oc_q] <= (ic_q == '0) ? prod_x : acc[oc_q] + prod_x;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q       <= '0;
      ic_q      <= '0;
      oc_q      <= '0;
      sc_q      <= '0;
      busy      <= 1'b0;
      done_pend <= 1'b0;
      ser_on    <= 1'b0;
    end else begin
      if (in_valid && in_ready) begin
        x_q  <= in_data;
        oc_q <= '0;
        busy <= 1'b1;
      end
      if (busy) begin
        if (last_oc) begin
          busy <= 1'b0;
          oc_q <= '0;
          ic_q <= last_ic ? '0 : ic_q + 1'b1;
          if (last_ic) done_pend <= 1'b1;
        end else begin
          oc_q <= oc_q + 1'b1;
        end
      end
      if (start) begin
        done_pend <= 1'b0;
        ser_on    <= 1'b1;
        sc_q      <= '0;
      end else if (ser_on) begin
        if (last_sc) ser_on <= 1'b0;
        else         sc_q   <= sc_q + 1'b1;
      end
    end
  end

  assign out_valid = ser_on;
  assign out_first = ser_on && (sc_q == '0);
  assign out_ch    = sc_q;
endmodule

// File: rtl/pw_conv_serial_chk.sv
module pw_conv_serial_chk #(
  parameter int COUT = 4,
  parameter int DBUF = 1,
  localparam int OCW = (COUT > 1) ? $clog2(COUT) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_first,
  input logic [OCW-1:0] out_ch
);
  // R5
  hold_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  // R7
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ch != OCW'(COUT - 1) |=> out_valid && out_ch == $past(out_ch) + 1'b1);

  // R7
  burst_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_ch == '0);

  // R8
  first_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid && out_ch == '0);

  // R8
  first_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_first);

  // R10
  single_bank_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (DBUF == 0) && out_valid |-> !in_ready);
endmodule

bind pw_conv_serial pw_conv_serial_chk #(.COUT(COUT), .DBUF(DBUF)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_first(out_first), .out_ch(out_ch));

// File: tb/pw_conv_serial_bench.sv
module pw_conv_serial_bench;
  localparam int CIN = 4, COUT = 4;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic a_iv = 0, a_rdy, a_ov, a_of;
  logic signed [7:0] a_d = 0;
  logic [1:0] a_ch;
  logic signed [19:0] a_q;
  logic b_iv = 0, b_rdy, b_ov, b_of;
  logic signed [7:0] b_d = 0;
  logic [1:0] b_ch;
  logic signed [19:0] b_q;

  pw_conv_serial u_pw_conv_serial (.clk(clk), .rst_n(rst_n), .in_valid(a_iv), .in_ready(a_rdy),
    .in_data(a_d), .out_valid(a_ov), .out_first(a_of), .out_ch(a_ch), .out_data(a_q));
  pw_conv_serial #(.DBUF(0)) u_pw_conv_serial_sb (.clk(clk), .rst_n(rst_n), .in_valid(b_iv),
    .in_ready(b_rdy), .in_data(b_d), .out_valid(b_ov), .out_first(b_of), .out_ch(b_ch), .out_data(b_q));

  int nchk = 0, nfail = 0, cyc = 0;
  always @(posedge clk) cyc++;

  int cap_d [64], cap_ch [64], cap_f [64], cap_c [64];
  int cap_n = 0;
  bit use_b = 0;
  bit b_stall_bad = 0;
  always @(negedge clk) begin
    if ((use_b ? b_ov : a_ov) && cap_n < 64) begin
      cap_d[cap_n]  = use_b ? int'(b_q) : int'(a_q);
      cap_ch[cap_n] = use_b ? int'(b_ch) : int'(a_ch);
      cap_f[cap_n]  = use_b ? int'(b_of) : int'(a_of);
      cap_c[cap_n]  = cyc;
      cap_n++;
    end
    if (b_ov && b_rdy) b_stall_bad = 1;
  end

  int px [8][CIN];
  bit acc_ov;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wgt(input int ic, input int oc);
    int v;
    v = ((ic * 4 + oc) * 29 + 3) & 255;
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int expect_sum(input int p, input int oc);
    int s = 0;
    for (int ic = 0; ic < CIN; ic++) s += px[p][ic] * wgt(ic, oc);
    return s;
  endfunction

  task automatic send(input int x);
    if (use_b) begin b_iv = 1; b_d = 8'(x); end
    else       begin a_iv = 1; a_d = 8'(x); end
    while (!(use_b ? b_rdy : a_rdy)) @(negedge clk);
    acc_ov = use_b ? b_ov : a_ov;
    @(negedge clk);
    a_iv = 0; b_iv = 0;
  endtask

  task automatic run(input int np, input bit chk_hold, input string tag);
    int n;
    cap_n = 0;
    for (int p = 0; p < np; p++)
      for (int ic = 0; ic < CIN; ic++) begin
        send(px[p][ic]);
        if (chk_hold && ic < CIN - 1) begin
          n = 0;
          while (!(use_b ? b_rdy : a_rdy) && n < 50) begin n++; @(negedge clk); end
          // R5
          check(n == COUT, {tag, " R5 hold length"}, n, COUT);
        end
      end
    n = 0;
    while (cap_n < np * COUT && n < 200) begin n++; @(negedge clk); end
    repeat (3) @(negedge clk);
    // R7
    check(cap_n == np * COUT, {tag, " R7 result count"}, cap_n, np * COUT);
    for (int p = 0; p < np; p++)
      for (int oc = 0; oc < COUT; oc++) begin
        int k = p * COUT + oc;
        if (k < cap_n) begin
          // R4 R3
          check(cap_d[k] == expect_sum(p, oc), {tag, " R4 sum"}, cap_d[k], expect_sum(p, oc));
          // R7
          check(cap_ch[k] == oc, {tag, " R7 channel order"}, cap_ch[k], oc);
          // R8
          check(cap_f[k] == (oc == 0), {tag, " R8 first flag"}, cap_f[k], int'(oc == 0));
          if (oc > 0)
            check(cap_c[k] == cap_c[k-1] + 1, {tag, " R7 consecutive"}, cap_c[k] - cap_c[k-1], 1);
        end
      end
  endtask

  task automatic t_reset();
    @(negedge clk);
    // R1
    check(a_rdy == 1, "R1 in_ready after reset", a_rdy, 1);
    check(a_ov == 0, "R1 out_valid after reset", a_ov, 0);
    check(b_rdy == 1 && b_ov == 0, "R1 single-bank idle", {b_rdy, b_ov}, 2);
  endtask

  task automatic t_basic();
    use_b = 0;
    px[0] = '{1, 2, 3, 4};
    // R2 R3 R4 R5
    run(1, 1, "basic");
  endtask

  task automatic t_extreme();
    use_b = 0;
    px[0] = '{-128, -128, -128, -128};
    px[1] = '{127, -1, 0, -128};
    // R4 R6 extremes and clearing between pixels
    run(2, 0, "extreme R6");
  endtask

  task automatic t_overlap();
    use_b = 0;
    px[0] = '{10, -20, 30, -40};
    cap_n = 0;
    for (int ic = 0; ic < CIN; ic++) send(px[0][ic]);
    px[1] = '{5, 6, -7, 8};
    send(px[1][0]);
    // R9
    check(acc_ov == 1, "R9 next pixel accepted during output", acc_ov, 1);
    for (int ic = 1; ic < CIN; ic++) send(px[1][ic]);
    repeat (30) @(negedge clk);
    for (int p = 0; p < 2; p++)
      for (int oc = 0; oc < COUT; oc++)
        check(cap_d[p*COUT+oc] == expect_sum(p, oc), "R9 R6 overlapped sums",
              cap_d[p*COUT+oc], expect_sum(p, oc));
  endtask

  task automatic t_single();
    use_b = 1;
    b_stall_bad = 0;
    px[0] = '{-3, 100, -100, 77};
    px[1] = '{0, 0, 0, 1};
    px[2] = '{-128, 127, -128, 127};
    run(3, 1, "single");
    // R10
    check(b_stall_bad == 0, "R10 in_ready low during output", b_stall_bad, 0);
    use_b = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_extreme();
    t_overlap();
    t_single();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule